// File: doc/BRIEF.md
# Programmable Interval Interrupt Timer

This block raises an interrupt request at a fixed, software-chosen interval. A reference strobe (`ref_tick`, one pulse per reference period, in the `clk` domain) is first selected as the timer source. When the synthesizer-mode pin was high during reset, the source is the reference divided by 128. Otherwise the raw reference is used. The source then passes an optional divide-by-512 stage, chosen by a prescale bit, and a fixed divide-by-4 stage. The result drives an 8-bit down-counting modulus counter. Each time the count completes, the counter reloads, and a request is posted at the programmed priority level.

Software programs two registers through a simple write port and can read them back. The timing register holds the modulus and the prescale bit. The control register holds the vector, the request level and a freeze-stop enable. A pending request stays on `irq_level` until an acknowledge arrives carrying the same level. The vector is then returned for one cycle. The timer keeps counting while its request is disabled. It can be held by the debug freeze input.

The counter has two states, `CNT_OFF` and `CNT_RUN`:
- `CNT_OFF` moves to `CNT_RUN` when a non-zero modulus is present.
- `CNT_RUN` moves back to `CNT_OFF` as soon as the modulus becomes zero.
- `CNT_RUN` loops on itself with a reload at every completion.

The request logic has three states, `REQ_IDLE`, `REQ_PEND` and `REQ_VEC`:
- `REQ_IDLE` moves to `REQ_PEND` on a completion while the level is non-zero.
- `REQ_PEND` moves to `REQ_VEC` on an acknowledge at the matching level.
- `REQ_PEND` moves back to `REQ_IDLE` if the level is cleared.
- `REQ_VEC` moves to `REQ_IDLE` after one cycle. It moves to `REQ_PEND` instead if a completion coincides.

Top module: `tick_irq_timer`

## Requirements
- R1: After reset the modulus is 0, the vector is 0x0F, the level is 0 and the freeze-stop bit is 0. The prescale bit resets to the inverse of `pll_sel_pin`, which is sampled during reset. No request and no vector are presented after reset.
- R2: The timing register is written at `wr_addr`=0: bits [7:0] are the modulus M and bit [8] is the prescale bit. With `pll_sel_pin` low at reset, prescale 0 and `ref_tick` high every cycle, requests follow each other every 4*M cycles. Starting from the stopped state, the first request appears on `irq_level` 4*M+1 cycles after the write edge.
- R3: With `pll_sel_pin` high at reset, the source is divided by 128. With prescale 0 the interval is 512*M reference ticks, and the first request appears 512*M+1 cycles after the write edge.
- R4: A prescale bit of 1 multiplies the interval by 512.
- R5: A non-zero modulus written during a count does not change the period in progress. It is used from the following reload onward.
- R6: Writing a modulus of 0 stops the counter at once, and no further request follows.
- R7: The control register is written at `wr_addr`=1: bits [7:0] are the vector, bits [10:8] the level and bit [11] the freeze-stop bit. Level 0 suppresses requests, and levels 1 to 7 are presented as-is. While the level is 0 the counter keeps its schedule, so later requests stay on the grid set by the modulus write.
- R8: A pending request holds its level on `irq_level` until `iack_valid` arrives with `iack_level` equal to that level. An acknowledge at a different level is ignored. A matching acknowledge makes `vec_valid` high with the vector for exactly the next cycle.
- R9: While `freeze` is high and the freeze-stop bit is 1, the timer loses one reference tick per cycle. With the freeze-stop bit at 0, `freeze` has no effect.
- R10: `rd_data` returns the register selected by `rd_addr`. For the timing register it gives {3'b0, prescale, modulus}. For the control register it gives {freeze-stop, level, vector}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_sel_pin | input | 1 | Source-mode pin, sampled while reset is low |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| freeze | input | 1 | Debug freeze request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = timing register, 1 = control register |
| wr_data | input | 12 | Write data |
| rd_addr | input | 1 | Read select |
| rd_data | output | 12 | Read data of the selected register |
| iack_valid | input | 1 | Interrupt acknowledge strobe |
| iack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Level of the pending request, 0 when none |
| vec_valid | output | 1 | Vector valid, one cycle after a matching acknowledge |
| vec_out | output | 8 | Returned vector |

## Verification
The interval is measured between successive requests for several setups:
- two modulus values, which tells the reload from a fixed delay;
- the prescale bit set, which shows the 512 factor;
- a reset in synthesizer mode, which shows the 128 source division.

Two mid-count writes are tried. A new non-zero modulus must leave one more old-length gap, which separates a deferred load from an immediate one. A zero modulus must silence the timer at once.

With the level held at 0 the timer is left running, and the alignment of the first request after enabling shows that counting went on. Freeze is applied for a known number of cycles with the stop bit set and cleared, so the gap either grows by exactly that number or stays unchanged. Acknowledges are given at a wrong level and then at the right one, to show the request holds and the vector appears once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned MOD_W   = 8;
    localparam int unsigned LVL_W   = 3;
    localparam int unsigned VEC_W   = 8;
    localparam int unsigned REG_W   = 12;
    localparam int unsigned SRC_DIV = 128;
    localparam int unsigned PRE_DIV = 512;
    localparam int unsigned FIX_DIV = 4;
    localparam logic [VEC_W-1:0] VEC_RST = 8'h0F;

    typedef enum logic {
        CNT_OFF,
        CNT_RUN
    } cnt_state_e;

    typedef enum logic [1:0] {
        REQ_IDLE,
        REQ_PEND,
        REQ_VEC
    } req_state_e;
endpackage

// File: rtl/tmr_div_stage.sv
module tmr_div_stage #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bypass,
    input  logic in_tick,
    output logic out_tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || bypass) begin
            cnt_q <= '0;
        end else if (in_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (bypass) out_tick = in_tick;
        else        out_tick = in_tick && (cnt_q == LAST);
    end

    // R2: an active divider never emits two ticks back to back
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tick && !bypass && !clr) |=> !out_tick || bypass || clr);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int unsigned SDIV = SRC_DIV,
    parameter int unsigned PDIV = PRE_DIV,
    parameter int unsigned FDIV = FIX_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic halt,
    input  logic pll_mode,
    input  logic prescale,
    input  logic ref_tick,
    output logic cnt_tick
);
    localparam int unsigned NSTG = 3;
    localparam int unsigned DIVS [NSTG] = '{SDIV, PDIV, FDIV};

    logic [NSTG:0]   chain;
    logic [NSTG-1:0] byp;

    assign byp      = {1'b0, ~prescale, ~pll_mode};
    assign chain[0] = ref_tick && !halt;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        tmr_div_stage #(.DIV(DIVS[g])) i_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .bypass  (byp[g]),
            .in_tick (chain[g]),
            .out_tick(chain[g+1])
        );
    end

    assign cnt_tick = chain[NSTG];

    // R9: nothing reaches the counter while it is held by freeze
    p_halt_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !cnt_tick);
endmodule

// File: rtl/tmr_modcount.sv
module tmr_modcount
    import tmr_pkg::*;
#(
    parameter int unsigned MW = MOD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] modulus,
    input  logic          cnt_tick,
    output logic          running,
    output logic          expire
);
    localparam logic [MW-1:0] ONE = MW'(1);

    cnt_state_e    state_q, state_d;
    logic [MW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CNT_OFF: begin
                if (modulus != '0) begin
                    state_d = CNT_RUN;
                    cnt_d   = modulus;
                end
            end
            CNT_RUN: begin
                if (modulus == '0) begin
                    state_d = CNT_OFF;
                    cnt_d   = '0;
                end else if (cnt_tick) begin
                    cnt_d = (cnt_q == ONE) ? modulus : cnt_q - ONE;
                end
            end
            default: state_d = CNT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        running = (state_q == CNT_RUN);
        expire  = (state_q == CNT_RUN) && (modulus != '0) && cnt_tick && (cnt_q == ONE);
    end

    // R6: a running count is never zero
    p_run_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt_q != '0);
    // R6: a zero modulus yields no completion
    p_zero_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (modulus == '0) |-> !expire);
    // R5: each completion reloads the current modulus
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt_q == $past(modulus));
endmodule

// File: rtl/tmr_request.sv
module tmr_request
    import tmr_pkg::*;
#(
    parameter int unsigned LW = LVL_W,
    parameter int unsigned VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expire,
    input  logic [LW-1:0] level,
    input  logic [VW-1:0] vector,
    input  logic          iack_valid,
    input  logic [LW-1:0] iack_level,
    output logic [LW-1:0] irq_level,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out
);
    req_state_e state_q, state_d;
    logic       post;
    logic       ack_hit;

    assign post    = expire && (level != '0);
    assign ack_hit = iack_valid && (iack_level == level);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: if (post) state_d = REQ_PEND;
            REQ_PEND: begin
                if (level == '0)  state_d = REQ_IDLE;
                else if (ack_hit) state_d = REQ_VEC;
            end
            REQ_VEC:  state_d = post ? REQ_PEND : REQ_IDLE;
            default:  state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_level = '0;
        vec_valid = 1'b0;
        vec_out   = '0;
        unique case (state_q)
            REQ_IDLE: ;
            REQ_PEND: irq_level = level;
            REQ_VEC: begin
                vec_valid = 1'b1;
                vec_out   = vector;
            end
            default: ;
        endcase
    end

    // R8: the vector appears only right after an acknowledge
    p_vec_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(iack_valid));
    // R8: the vector lasts a single cycle
    p_vec_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // R8: a request without a matching acknowledge stays posted
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0 && !(iack_valid && iack_level == irq_level) && level == irq_level)
        |=> irq_level == $past(irq_level) || level != $past(level));
endmodule

// File: rtl/tick_irq_timer.sv
module tick_irq_timer
    import tmr_pkg::*;
#(
    parameter int unsigned MW   = MOD_W,
    parameter int unsigned LW   = LVL_W,
    parameter int unsigned VW   = VEC_W,
    parameter int unsigned RW   = REG_W,
    parameter int unsigned SDIV = SRC_DIV,
    parameter int unsigned PDIV = PRE_DIV,
    parameter int unsigned FDIV = FIX_DIV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pll_sel_pin,
    input  logic          ref_tick,
    input  logic          freeze,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [RW-1:0] wr_data,
    input  logic          rd_addr,
    output logic [RW-1:0] rd_data,
    input  logic          iack_valid,
    input  logic [LW-1:0] iack_level,
    output logic [LW-1:0] irq_level,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out
);
    localparam int unsigned FRZ_BIT = VW + LW;
    localparam int unsigned TPAD    = RW - MW - 1;

    logic          pll_q, pre_q, frz_q;
    logic [MW-1:0] mod_q;
    logic [LW-1:0] lvl_q;
    logic [VW-1:0] vec_q;
    logic          cnt_tick, running, expire;
    logic          unused_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_q <= pll_sel_pin;
            pre_q <= ~pll_sel_pin;
            mod_q <= '0;
            lvl_q <= '0;
            vec_q <= VEC_RST;
            frz_q <= 1'b0;
        end else if (wr_en) begin
            if (!wr_addr) begin
                mod_q <= wr_data[MW-1:0];
                pre_q <= wr_data[MW];
            end else begin
                vec_q <= wr_data[VW-1:0];
                lvl_q <= wr_data[VW +: LW];
                frz_q <= wr_data[FRZ_BIT];
            end
        end
    end

    assign unused_wr = ^wr_data[RW-1:MW+1];

    always_comb begin
        if (!rd_addr) rd_data = {{TPAD{1'b0}}, pre_q, mod_q};
        else          rd_data = {frz_q, lvl_q, vec_q};
    end

    tmr_prescale #(.SDIV(SDIV), .PDIV(PDIV), .FDIV(FDIV)) i_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!running),
        .halt    (freeze && frz_q),
        .pll_mode(pll_q),
        .prescale(pre_q),
        .ref_tick(ref_tick),
        .cnt_tick(cnt_tick)
    );

    tmr_modcount #(.MW(MW)) i_modcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .modulus (mod_q),
        .cnt_tick(cnt_tick),
        .running (running),
        .expire  (expire)
    );

    tmr_request #(.LW(LW), .VW(VW)) i_request (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .level     (lvl_q),
        .vector    (vec_q),
        .iack_valid(iack_valid),
        .iack_level(iack_level),
        .irq_level (irq_level),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    // R7: a posted level is always the programmed one
    p_level_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> irq_level == lvl_q);
    // R6: a stopped timer posts nothing new
    p_off_no_post_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && irq_level == '0) |=> irq_level == '0);
endmodule

// File: tb/test_tick_irq_timer.sv
`timescale 1ns/1ps
module test_tick_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pll_sel_pin = 1'b0;
    logic        ref_tick = 1'b1;
    logic        freeze = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [11:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [11:0] rd_data;
    logic        iack_valid = 1'b0;
    logic [2:0]  iack_level = '0;
    logic [2:0]  irq_level;
    logic        vec_valid;
    logic [7:0]  vec_out;

    always #2.5 clk = ~clk;

    tick_irq_timer i_tick_irq_timer (
        .clk(clk), .rst_n(rst_n), .pll_sel_pin(pll_sel_pin), .ref_tick(ref_tick),
        .freeze(freeze), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .iack_valid(iack_valid),
        .iack_level(iack_level), .irq_level(irq_level), .vec_valid(vec_valid),
        .vec_out(vec_out)
    );

    typedef struct { int gap; string tag; } gap_t;

    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    int   rises = 0, last_rise = 0, prev_rise = 0, last_wr = 0;
    bit   armed = 0, auto_ack = 1;
    logic [2:0] prev_lvl = '0;
    gap_t exp_gap[$];
    logic [7:0] exp_vec[$];
    event ev_rise;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (irq_level != 3'd0 && prev_lvl == 3'd0) begin
            rises++;
            last_rise = cyc;
            if (armed && exp_gap.size() > 0) begin
                gap_t e;
                e = exp_gap.pop_front();
                chk(cyc - prev_rise == e.gap, e.tag, cyc - prev_rise, e.gap);
            end
            prev_rise = cyc;
            armed = 1;
            -> ev_rise;
        end
        prev_lvl = irq_level;
        if (vec_valid && exp_vec.size() > 0) begin
            logic [7:0] v;
            v = exp_vec.pop_front();
            chk(vec_out == v, "R8", vec_out, v);
        end
        if (auto_ack) begin
            if (iack_valid) iack_valid = 1'b0;
            else if (irq_level != 3'd0) begin
                iack_valid = 1'b1;
                iack_level = irq_level;
            end
        end
    end

    task automatic wr(input logic a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 last_wr = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic a, input logic [11:0] e, input string req);
        @(negedge clk);
        rd_addr = a;
        #1 chk(rd_data == e, req, rd_data, e);
    endtask

    task automatic push_gap(input int g, input string t);
        gap_t e;
        e.gap = g; e.tag = t;
        exp_gap.push_back(e);
    endtask

    task automatic drain();
        while (exp_gap.size() > 0) @(negedge clk);
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0; pll_sel_pin = pin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int d, r0;
        do_reset(1'b0);
        // R1: reset state
        chk(irq_level == 3'd0, "R1", irq_level, 0);
        chk(vec_valid == 1'b0, "R1", vec_valid, 0);
        rd_chk(1'b0, 12'h100, "R1");
        rd_chk(1'b1, 12'h00F, "R1");

        // R10 readback, R2 interval
        wr(1'b1, 12'h342);
        rd_chk(1'b1, 12'h342, "R10");
        repeat (4) exp_vec.push_back(8'h42);
        armed = 0;
        wr(1'b0, 12'h005);
        rd_chk(1'b0, 12'h005, "R10");
        @(ev_rise);
        chk(last_rise - last_wr == 21, "R2", last_rise - last_wr, 21);
        repeat (3) push_gap(20, "R2");
        drain();
        repeat (4) @(negedge clk);
        chk(exp_vec.size() == 0, "R8", exp_vec.size(), 0);

        // R5 deferred modulus
        armed = 0;
        @(ev_rise);
        repeat (3) @(negedge clk);
        wr(1'b0, 12'h003);
        push_gap(20, "R5"); push_gap(12, "R5"); push_gap(12, "R5");
        drain();

        // R6 zero stops
        @(ev_rise);
        repeat (3) @(negedge clk);
        wr(1'b0, 12'h000);
        r0 = rises;
        repeat (200) @(negedge clk);
        chk(rises == r0, "R6", rises - r0, 0);
        chk(irq_level == 3'd0, "R6", irq_level, 0);

        // R7 level 0 suppresses but counting continues
        wr(1'b1, 12'h042);
        wr(1'b0, 12'h004);
        d = last_wr;
        r0 = rises;
        repeat (100) @(negedge clk);
        chk(rises == r0, "R7", rises - r0, 0);
        wr(1'b1, 12'h342);
        @(ev_rise);
        chk((last_rise - d) > 100 && ((last_rise - d - 1) % 16) == 0, "R7",
            last_rise - d, 16);

        // R8 acknowledge matching
        auto_ack = 0;
        @(negedge clk);
        iack_valid = 1'b0;
        while (irq_level == 3'd0) @(negedge clk);
        chk(irq_level == 3'd3, "R8", irq_level, 3);
        iack_valid = 1'b1; iack_level = 3'd5;
        @(negedge clk);
        iack_valid = 1'b0;
        chk(vec_valid == 1'b0, "R8", vec_valid, 0);
        chk(irq_level == 3'd3, "R8", irq_level, 3);
        repeat (30) @(negedge clk);
        chk(irq_level == 3'd3, "R8", irq_level, 3);
        iack_valid = 1'b1; iack_level = 3'd3;
        @(negedge clk);
        iack_valid = 1'b0;
        chk(vec_valid == 1'b1 && vec_out == 8'h42, "R8", {vec_valid, vec_out}, 12'h142);
        @(negedge clk);
        chk(vec_valid == 1'b0, "R8", vec_valid, 0);
        wr(1'b0, 12'h000);
        auto_ack = 1;
        repeat (20) @(negedge clk);

        // R9 freeze with stop bit set
        wr(1'b1, 12'hB42);
        wr(1'b0, 12'h005);
        armed = 0;
        @(ev_rise);
        repeat (3) @(negedge clk);
        push_gap(60, "R9"); push_gap(20, "R9");
        freeze = 1'b1;
        repeat (40) @(negedge clk);
        freeze = 1'b0;
        drain();
        // R9 freeze ignored with stop bit clear
        wr(1'b1, 12'h342);
        armed = 0;
        @(ev_rise);
        repeat (3) @(negedge clk);
        push_gap(20, "R9"); push_gap(20, "R9");
        freeze = 1'b1;
        repeat (40) @(negedge clk);
        freeze = 1'b0;
        drain();
        wr(1'b0, 12'h000);
        repeat (20) @(negedge clk);

        // R4 prescale by 512
        wr(1'b0, 12'h102);
        rd_chk(1'b0, 12'h102, "R10");
        armed = 0;
        @(ev_rise);
        push_gap(4096, "R4"); push_gap(4096, "R4");
        drain();
        wr(1'b0, 12'h000);

        // R3 synthesizer mode source
        do_reset(1'b1);
        rd_chk(1'b0, 12'h000, "R1");
        rd_chk(1'b1, 12'h00F, "R1");
        wr(1'b1, 12'h342);
        armed = 0;
        wr(1'b0, 12'h003);
        @(ev_rise);
        chk(last_rise - last_wr == 1537, "R3", last_rise - last_wr, 1537);
        push_gap(1536, "R3");
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule